// File: doc/BRIEF.md
# Codirectional octet line encoder

The block turns one PCM byte per frame into a continuous codirectional dual-rail line signal. The byte arrives as a serial burst of eight bits. Each bit is taken on a bit-clock enable while the time-slot strobe is high. The captured byte goes into a small slip buffer. The line side runs on a separate unit-interval enable at four times the line bit rate. It takes one byte from the buffer for each octet and sends every bit as four unit intervals.

Marks alternate polarity from bit to bit. The last bit of each octet breaks the alternation with a deliberate polarity violation, so that a receiver can find the octet boundary. An alarm input removes that violation and leaves the rest of the code unchanged. The capture side and the line side keep an agreed rate but no fixed phase. When the rates drift apart, the buffer runs empty or full. The block then repeats or drops a whole byte and pulses a flag to report the slip.

Both sides share one fast clock, `clk_i`. Each side advances only on its own enable input.

Top module: `codir_tx_enc`

## Requirements
- R1: While `slot_i` is high, each clock with `bit_en_i` high shifts `pcm_i` into the capture register. The first bit becomes the most significant bit. The byte is complete on the eighth such bit, and it is then written to the buffer.
- R2: If `slot_i` falls before eight bits have been taken, the partial byte is discarded and nothing is written.
- R3: Each bit lasts four unit intervals, and the line moves to the next unit only on a clock with `ui_en_i` high. A 1 bit marks the pattern 1100 and a 0 bit marks 1010, first unit first. The outputs do not change on clocks without `ui_en_i`.
- R4: A mark of positive polarity drives `pos_o`, and a mark of negative polarity drives `neg_o`. The two rails are never high together. From one bit to the next, the mark polarity alternates.
- R5: With `alarm_i` low, the last bit of each octet (its least significant bit) repeats the polarity of the bit before it.
- R6: With `alarm_i` high at the boundary into the last bit, that bit alternates like any other bit, so no violation is sent.
- R7: The buffer holds two bytes in first-in first-out order. The next byte is taken from it at the end of the last unit of each octet.
- R8: If the buffer is empty at an octet boundary, the previous byte is sent again. `ins_o` then pulses high for one clock.
- R9: A byte completed while the buffer already holds two bytes is dropped. `del_o` then pulses high for one clock, and the bytes already held keep their order.
- R10: Reset clears the buffer, the flags and the unit and bit position. It sets positive polarity and makes the held byte 0x00. The first octet after reset is therefore an all-zero octet whose first mark is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Capture bit-clock enable |
| slot_i | input | 1 | Transmit time-slot strobe |
| pcm_i | input | 1 | Serial PCM input data |
| ui_en_i | input | 1 | Line unit-interval enable |
| alarm_i | input | 1 | Suppresses the octet violation |
| pos_o | output | 1 | Positive mark rail |
| neg_o | output | 1 | Negative mark rail |
| ins_o | output | 1 | Byte repeated, because the buffer was empty |
| del_o | output | 1 | Byte dropped, because the buffer was full |

## Verification
The bench records every octet unit by unit on both rails and compares it with a model of the code. Each data pattern is tried with the alarm both low and high. A design that places the violation on the wrong bit, that forgets to carry the polarity from one octet to the next, or that ignores the alarm will show a rail waveform that differs from the model. The bench also empties the buffer, overfills it and cuts a time slot short. A buffer that loses its order, that reports the wrong flag or that stores a partial byte will change the octets that follow. A reset in the middle of a run must bring back the all-zero octet that starts with a positive mark.

// File: rtl/codir_pkg.sv
package codir_pkg;
  // Unit-interval mark patterns, first unit in the MSB.
  localparam logic [3:0] PAT_ONE  = 4'b1100;
  localparam logic [3:0] PAT_ZERO = 4'b1010;
endpackage

// File: rtl/codir_capture.sv
module codir_capture #(
  parameter int unsigned OCT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             slot_i,
  input  logic             data_i,
  output logic [OCT_W-1:0] byte_o,
  output logic             valid_o
);
  localparam int unsigned CNT_W = $clog2(OCT_W);

  logic [CNT_W-1:0] cnt_q;
  logic [OCT_W-1:0] sh_q;
  logic [OCT_W-1:0] sh_d;

  assign sh_d = {sh_q[OCT_W-2:0], data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!slot_i) begin
        cnt_q <= '0;  // partial byte is abandoned
      end else if (bit_en_i) begin
        sh_q <= sh_d;
        if (cnt_q == CNT_W'(OCT_W - 1)) begin
          cnt_q   <= '0;
          byte_o  <= sh_d;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/codir_slip_buf.sv
module codir_slip_buf #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         avail_o,
  output logic         ins_o,
  output logic         del_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, do_wr, do_rd, drop, under;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr_i && (!full || rd_i);
  assign drop  = wr_i && full && !rd_i;
  assign do_rd = rd_i && !empty;
  assign under = rd_i && empty;

  assign rd_data_o = mem_q[rptr_q];
  assign avail_o   = !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ins_o  <= 1'b0;
      del_o  <= 1'b0;
    end else begin
      ins_o <= under;
      del_o <= drop;
      if (do_wr) begin
        mem_q[wptr_q] <= wr_data_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (do_rd) rptr_q <= nxt(rptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/codir_line_enc.sv
module codir_line_enc
  import codir_pkg::*;
#(
  parameter int unsigned OCT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ui_en_i,
  input  logic             alarm_i,
  input  logic [OCT_W-1:0] next_i,
  input  logic             next_ok_i,
  output logic             load_o,
  output logic             pos_o,
  output logic             neg_o
);
  localparam int unsigned BIT_W = $clog2(OCT_W);

  logic [BIT_W-1:0] bit_q, nbit, idx;
  logic [1:0]       unit_q;
  logic             pol_q;  // 0: positive marks
  logic [OCT_W-1:0] cur_q;
  logic             last_unit, last_bit, viol, lvl;
  logic [3:0]       pat;

  assign last_unit = (unit_q == 2'd3);
  assign last_bit  = (bit_q == BIT_W'(OCT_W - 1));
  assign nbit      = last_bit ? '0 : bit_q + 1'b1;
  // polarity is held into the octet's last bit unless alarmed
  assign viol      = (nbit == BIT_W'(OCT_W - 1)) && !alarm_i;
  assign load_o    = ui_en_i && last_unit && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      unit_q <= '0;
      pol_q  <= 1'b0;
      cur_q  <= '0;
    end else if (ui_en_i) begin
      unit_q <= unit_q + 1'b1;
      if (last_unit) begin
        bit_q <= nbit;
        pol_q <= viol ? pol_q : !pol_q;
        if (last_bit && next_ok_i) cur_q <= next_i;
      end
    end
  end

  assign idx   = BIT_W'(OCT_W - 1) - bit_q;
  assign pat   = cur_q[idx] ? PAT_ONE : PAT_ZERO;
  assign lvl   = pat[2'd3 - unit_q];
  assign pos_o = lvl && !pol_q;
  assign neg_o = lvl && pol_q;
endmodule

// File: rtl/codir_tx_enc.sv
module codir_tx_enc #(
  parameter int unsigned OCT_W = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic slot_i,
  input  logic pcm_i,
  input  logic ui_en_i,
  input  logic alarm_i,
  output logic pos_o,
  output logic neg_o,
  output logic ins_o,
  output logic del_o
);
  logic [OCT_W-1:0] cap_byte, buf_byte;
  logic             cap_vld, buf_avail, load;

  codir_capture #(.OCT_W(OCT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .slot_i   (slot_i),
    .data_i   (pcm_i),
    .byte_o   (cap_byte),
    .valid_o  (cap_vld)
  );

  codir_slip_buf #(.W(OCT_W), .DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cap_vld),
    .wr_data_i (cap_byte),
    .rd_i      (load),
    .rd_data_o (buf_byte),
    .avail_o   (buf_avail),
    .ins_o     (ins_o),
    .del_o     (del_o)
  );

  codir_line_enc #(.OCT_W(OCT_W)) u_enc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ui_en_i   (ui_en_i),
    .alarm_i   (alarm_i),
    .next_i    (buf_byte),
    .next_ok_i (buf_avail),
    .load_o    (load),
    .pos_o     (pos_o),
    .neg_o     (neg_o)
  );
endmodule

// File: rtl/codir_tx_enc_chk.sv
module codir_tx_enc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ui_en_i,
  input logic pos_o,
  input logic neg_o,
  input logic ins_o,
  input logic del_o
);
  p_rails_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ui_en_i |=> ($stable(pos_o) && $stable(neg_o)));

  p_ins_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |=> !ins_o);

  p_ins_at_ui_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> $past(ui_en_i));

  p_del_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_o |=> !del_o);
endmodule

bind codir_tx_enc codir_tx_enc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ui_en_i (ui_en_i),
  .pos_o   (pos_o),
  .neg_o   (neg_o),
  .ins_o   (ins_o),
  .del_o   (del_o)
);

// File: tb/codir_tx_enc_bench.sv
module codir_tx_enc_bench;
  localparam int CLK_PERIOD = 10;
  // {alarm, byte}
  localparam logic [8:0] VEC [7] = '{9'h0A9, 9'h080, 9'h001, 9'h110,
                                     9'h1FF, 9'h000, 9'h05A};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, slot = 1'b0, pcm = 1'b0, ui_en = 1'b0, alarm = 1'b0;
  logic pos, neg, ins, del;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  // reference model
  logic [7:0] m_cur, m_q0, m_q1;
  int         m_cnt;
  logic       m_pol;

  always #(CLK_PERIOD/2) clk = ~clk;

  codir_tx_enc u_codir_tx_enc (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .slot_i(slot),
    .pcm_i(pcm), .ui_en_i(ui_en), .alarm_i(alarm),
    .pos_o(pos), .neg_o(neg), .ins_o(ins), .del_o(del)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cur = 8'h00; m_pol = 1'b0; m_cnt = 0; m_q0 = '0; m_q1 = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 0; slot = 0; pcm = 0; ui_en = 0; alarm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Serial burst of nbits; full bursts go to the model buffer.
  task automatic put_byte(input logic [7:0] b, input int nbits, input string req);
    logic del_seen, exp_del;
    exp_del = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); slot = 1'b1; bit_en = 1'b1; pcm = b[7-i];
    end
    @(negedge clk); slot = 1'b0; bit_en = 1'b0; pcm = 1'b0;
    del_seen = 1'b0;
    repeat (4) begin @(negedge clk); del_seen |= del; end
    if (nbits == 8) begin
      if (m_cnt == 2) exp_del = 1'b1;
      else if (m_cnt == 1) begin m_q1 = b; m_cnt = 2; end
      else begin m_q0 = b; m_cnt = 1; end
    end
    chk(del_seen == exp_del, req, "deletion flag", 32'(del_seen), 32'(exp_del));
  endtask

  // One full octet of 32 unit intervals, compared with the model.
  task automatic run_octet(input logic alm, input string req);
    logic [31:0] gp, gn, ep, en;
    logic        ins_seen, exp_ins, p, lvl;
    logic [3:0]  pat;
    alarm = alm;
    p = m_pol;
    for (int bi = 0; bi < 8; bi++) begin
      pat = m_cur[7-bi] ? 4'b1100 : 4'b1010;
      for (int un = 0; un < 4; un++) begin
        lvl = pat[3-un];
        ep[31-(bi*4+un)] = lvl & ~p;
        en[31-(bi*4+un)] = lvl & p;
      end
      if (!(((bi + 1) % 8 == 7) && !alm)) p = ~p;
    end
    m_pol = p;
    ins_seen = 1'b0;
    for (int u = 0; u < 32; u++) begin
      @(negedge clk);
      gp[31-u] = pos; gn[31-u] = neg;
      ui_en = 1'b1;
      @(negedge clk);
      ui_en = 1'b0;
      ins_seen |= ins;
      @(negedge clk);
    end
    if (m_cnt == 0) exp_ins = 1'b1;
    else begin
      exp_ins = 1'b0; m_cur = m_q0; m_q0 = m_q1; m_cnt--;
    end
    chk(gp == ep, req, "positive rail", gp, ep);
    chk(gn == en, req, "negative rail", gn, en);
    chk(ins_seen == exp_ins, req, "insertion flag", 32'(ins_seen), 32'(exp_ins));
  endtask

  initial begin
    model_reset();
    do_reset();
    // R10: reset state, first unit of the zero octet is a positive mark
    chk(ins == 0 && del == 0, "R10", "flags after reset", {ins, del}, 0);
    chk(pos == 1 && neg == 0, "R10", "first unit after reset", {pos, neg}, 2'b10);

    // R1 R3 R4 R5 R6 R7: table of bytes, alarm per entry
    for (int i = 0; i < 7; i++) begin
      put_byte(VEC[i][7:0], 8, "R1");
      run_octet(VEC[i][8], (i == 0) ? "R10" : (VEC[i][8] ? "R6" : "R5"));
    end
    run_octet(1'b0, "R7");

    // R8: buffer empty, previous byte repeats
    run_octet(1'b0, "R8");

    // R2: short slot stores nothing, so the next boundary still underflows
    put_byte(8'h3C, 5, "R2");
    run_octet(1'b0, "R2");

    // R9: third byte dropped, first two kept in order
    put_byte(8'h11, 8, "R7");
    put_byte(8'h22, 8, "R7");
    put_byte(8'h33, 8, "R9");
    run_octet(1'b0, "R9");
    run_octet(1'b1, "R9");
    run_octet(1'b0, "R9");
    run_octet(1'b0, "R8");

    // R10: reset in mid-run
    put_byte(8'hC3, 8, "R1");
    do_reset();
    chk(ins == 0 && del == 0, "R10", "flags after second reset", {ins, del}, 0);
    run_octet(1'b0, "R10");
    run_octet(1'b0, "R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule